// File: doc/BRIEF.md
# PCI Initiator Timeout Monitor

This block sits beside the bus-master half of a PCI-style initiator and watches for two kinds of stall. The first is a transaction that keeps being answered with retry terminations. The second is a data phase in which the target takes too long to signal ready. Each check has its own 8-bit limit held in a control register, and a limit of zero turns that check off. When a limit is exceeded, the block sends the initiator a one-cycle abort pulse for that kind of timeout and sets a sticky error flag. Software clears the flag by writing one to it.

The initiator reports, once per clock, the start and successful end of each transaction, each retry termination, the start of each data phase, each clock spent waiting for target-ready, and the clock in which target-ready is seen. Software reaches the two registers through a simple word-addressed read/write port. Reads are combinational.

Top module: `pci_init_timeout_mon`

## Requirements
- R1: After reset, the control register (offset 0x0) reads 0x00008080: the retry limit in bits 15:8 and the ready-wait limit in bits 7:0, both 0x80. The status register (offset 0x4) reads 0, and both abort outputs are low.
- R2: A write to offset 0x0 updates both limit fields. Bits 31:16 of the control register always read as zero and ignore written data.
- R3: With a nonzero retry limit L, the retry count clears on a transaction start or a successful transaction end. The retry that would take the count to L+1 causes a timeout.
- R4: With a nonzero ready-wait limit L, the wait count clears on a data-phase start or when target-ready is seen. The (L+1)th consecutive waiting clock without such a clear causes a timeout.
- R5: A timeout drives its abort output high for exactly one cycle, in the cycle after the offending event, and clears that counter. Clear inputs take priority over a count event in the same cycle.
- R6: A limit of zero disables its check: no abort and no error flag, however many events arrive.
- R7: Status bit 1 is the ready-wait error flag and bit 0 is the retry error flag. Each is set in the same cycle as its abort pulse and stays set until cleared.
- R8: Writing 1 to a status bit clears that flag. Writing 0 leaves it unchanged. Status bits 31:2 read as zero.
- R9: If a timeout sets a flag in the same cycle that software writes 1 to clear it, the flag remains 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| txnStart | input | 1 | A new transaction begins |
| txnEnd | input | 1 | The transaction completed successfully |
| retryHit | input | 1 | The target ended this attempt with a retry |
| dataPhaseStart | input | 1 | A data phase begins |
| waitTrdy | input | 1 | This clock is spent waiting for target-ready |
| trdySeen | input | 1 | Target-ready is asserted this clock |
| retryAbort | output | 1 | One-cycle abort request: too many retries |
| trdyAbort | output | 1 | One-cycle abort request: ready wait too long |
| retryErr | output | 1 | Sticky retry error flag |
| trdyErr | output | 1 | Sticky ready-wait error flag |

## Verification
Retries are applied in runs of exactly L and L+1, so an off-by-one in the comparison shows up. Runs are broken by a transaction start or a successful end, to show that each clear path resets the count. Ready waits are applied in unbroken runs and in runs split by target-ready or a new data phase; this separates clock counting from event counting. Zero limits, write-zero versus write-one to status, and a flag set colliding with its clear separate the disable path, the clear path and the priority rule.

// File: rtl/pitm_pkg.sv
package pitm_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  // Strobes passed from register decode to the datapath
  typedef struct packed {
    logic wrLimits;
    logic clrRetryErr;
    logic clrTrdyErr;
  } pitm_strobe_t;
endpackage

// File: rtl/pitm_timeout_ctr.sv
module pitm_timeout_ctr #(
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clr,
  input  logic               evt,
  input  logic [LIMIT_W-1:0] limit,
  output logic               hit
);
  localparam logic [LIMIT_W-1:0] CNT_MAX = {LIMIT_W{1'b1}};

  logic [LIMIT_W-1:0] cnt;

  // A timeout occurs when one more event arrives with the count already at the limit
  assign hit = evt && !clr && (limit != '0) && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rstN)           cnt <= '0;
    else if (clr || hit) cnt <= '0;
    else if (evt && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // R6: a zero limit never produces a hit
  assert_no_hit_when_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (limit == '0) |-> !hit);
  // R5: the count restarts after a hit
  assert_clear_after_hit_R5: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> (cnt == '0));
endmodule

// File: rtl/pitm_ctrl.sv
module pitm_ctrl
  import pitm_pkg::*;
#(
  parameter int          LIMIT_W  = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 4'h0,
  parameter logic [ADDR_W-1:0] STAT_OFS = 4'h4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [LIMIT_W-1:0] retryLim,
  input  logic [LIMIT_W-1:0] trdyLim,
  input  logic               retryErr,
  input  logic               trdyErr,
  output pitm_strobe_t       strb,
  output logic [DATA_W-1:0]  regRdData
);
  localparam int CTRL_USED = 2 * LIMIT_W;

  logic selCtrl, selStat;
  assign selCtrl = (regAddr == CTRL_OFS);
  assign selStat = (regAddr == STAT_OFS);

  always_comb begin
    strb.wrLimits    = regWrEn && selCtrl;
    strb.clrRetryErr = regWrEn && selStat && regWrData[0];
    strb.clrTrdyErr  = regWrEn && selStat && regWrData[1];
  end

  always_comb begin
    regRdData = '0;
    if (selCtrl)      regRdData[CTRL_USED-1:0] = {retryLim, trdyLim};
    else if (selStat) regRdData[1:0] = {trdyErr, retryErr};
  end

  // R8: reserved status bits stay zero
  assert_stat_reserved_R8: assert property (@(posedge clk) disable iff (!rstN)
    selStat |-> (regRdData[DATA_W-1:2] == '0));
  // R2: reserved control bits stay zero
  assert_ctrl_reserved_R2: assert property (@(posedge clk) disable iff (!rstN)
    selCtrl |-> (regRdData[DATA_W-1:CTRL_USED] == '0));
endmodule

// File: rtl/pitm_datapath.sv
module pitm_datapath
  import pitm_pkg::*;
#(
  parameter int               LIMIT_W   = 8,
  parameter logic [LIMIT_W-1:0] LIMIT_RST = 8'h80
) (
  input  logic               clk,
  input  logic               rstN,
  input  pitm_strobe_t       strb,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               txnStart,
  input  logic               txnEnd,
  input  logic               retryHit,
  input  logic               dataPhaseStart,
  input  logic               waitTrdy,
  input  logic               trdySeen,
  output logic [LIMIT_W-1:0] retryLim,
  output logic [LIMIT_W-1:0] trdyLim,
  output logic               retryAbort,
  output logic               trdyAbort,
  output logic               retryErr,
  output logic               trdyErr
);
  logic retryTo, trdyTo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retryLim <= LIMIT_RST;
      trdyLim  <= LIMIT_RST;
    end else if (strb.wrLimits) begin
      retryLim <= regWrData[2*LIMIT_W-1:LIMIT_W];
      trdyLim  <= regWrData[LIMIT_W-1:0];
    end
  end

  pitm_timeout_ctr #(.LIMIT_W(LIMIT_W)) u_retryCtr (
    .clk(clk), .rstN(rstN), .clr(txnStart || txnEnd), .evt(retryHit),
    .limit(retryLim), .hit(retryTo));

  pitm_timeout_ctr #(.LIMIT_W(LIMIT_W)) u_trdyCtr (
    .clk(clk), .rstN(rstN), .clr(dataPhaseStart || trdySeen), .evt(waitTrdy),
    .limit(trdyLim), .hit(trdyTo));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retryAbort <= 1'b0;
      trdyAbort  <= 1'b0;
      retryErr   <= 1'b0;
      trdyErr    <= 1'b0;
    end else begin
      retryAbort <= retryTo;
      trdyAbort  <= trdyTo;
      // A hardware set takes priority over a software clear
      retryErr   <= retryTo || (retryErr && !strb.clrRetryErr);
      trdyErr    <= trdyTo  || (trdyErr  && !strb.clrTrdyErr);
    end
  end

  // R5: abort pulses last one cycle
  assert_retry_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    retryAbort |=> !retryAbort);
  assert_trdy_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    trdyAbort |=> !trdyAbort);
  // R7: a flag rises only together with its abort
  assert_retry_flag_src_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(retryErr) |-> retryAbort);
  assert_trdy_flag_src_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trdyErr) |-> trdyAbort);
  // R9: a set in the same cycle as a clear leaves the flag set
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (retryTo && strb.clrRetryErr) |=> retryErr);
  // R8: a clear with no set empties the flag
  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrTrdyErr && !trdyTo) |=> !trdyErr);
endmodule

// File: rtl/pci_init_timeout_mon.sv
module pci_init_timeout_mon
  import pitm_pkg::*;
#(
  parameter int LIMIT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              txnStart,
  input  logic              txnEnd,
  input  logic              retryHit,
  input  logic              dataPhaseStart,
  input  logic              waitTrdy,
  input  logic              trdySeen,
  output logic              retryAbort,
  output logic              trdyAbort,
  output logic              retryErr,
  output logic              trdyErr
);
  pitm_strobe_t       strb;
  logic [LIMIT_W-1:0] retryLim, trdyLim;

  pitm_ctrl #(.LIMIT_W(LIMIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .retryLim(retryLim), .trdyLim(trdyLim),
    .retryErr(retryErr), .trdyErr(trdyErr), .strb(strb), .regRdData(regRdData));

  pitm_datapath #(.LIMIT_W(LIMIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .txnStart(txnStart), .txnEnd(txnEnd), .retryHit(retryHit),
    .dataPhaseStart(dataPhaseStart), .waitTrdy(waitTrdy), .trdySeen(trdySeen),
    .retryLim(retryLim), .trdyLim(trdyLim), .retryAbort(retryAbort),
    .trdyAbort(trdyAbort), .retryErr(retryErr), .trdyErr(trdyErr));
endmodule

// File: tb/pci_init_timeout_mon_bench.sv
module pci_init_timeout_mon_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic txnStart = 0, txnEnd = 0, retryHit = 0, dataPhaseStart = 0, waitTrdy = 0, trdySeen = 0;
  logic retryAbort, trdyAbort, retryErr, trdyErr;
  int nChk = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_init_timeout_mon u_pci_init_timeout_mon (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .txnStart(txnStart),
    .txnEnd(txnEnd), .retryHit(retryHit), .dataPhaseStart(dataPhaseStart),
    .waitTrdy(waitTrdy), .trdySeen(trdySeen), .retryAbort(retryAbort),
    .trdyAbort(trdyAbort), .retryErr(retryErr), .trdyErr(trdyErr));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Inputs change at the falling edge; one rising edge later, results are sampled at the next falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    {txnStart, txnEnd, retryHit, dataPhaseStart, waitTrdy, trdySeen, regWrEn} = '0;
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [3:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  task automatic retries(input int n);
    for (int i = 0; i < n; i++) begin retryHit = 1'b1; tick(); end
    retryHit = 1'b0;
  endtask

  task automatic waits(input int n);
    for (int i = 0; i < n; i++) begin waitTrdy = 1'b1; tick(); end
    waitTrdy = 1'b0;
  endtask

  task automatic tReset();
    rdCheck("R1 ctrl", 4'h0, 32'h0000_8080);
    rdCheck("R1 stat", 4'h4, 32'h0);
    check("R1 aborts", {retryAbort, trdyAbort}, 0);
  endtask

  task automatic tLimitWrite();
    wrReg(4'h0, 32'hDEAD_0302);
    rdCheck("R2 limits", 4'h0, 32'h0000_0302);
  endtask

  task automatic tRetry();
    // limit 3: 3 retries are fine, the 4th times out
    txnStart = 1; tick(); txnStart = 0;
    retries(3);
    check("R3 no abort at limit", retryAbort, 0);
    retries(1);
    check("R5 retry abort", retryAbort, 1);
    check("R7 retry flag", retryErr, 1);
    tick();
    check("R5 pulse one cycle", retryAbort, 0);
    wrReg(4'h4, 32'h0);
    rdCheck("R8 write zero keeps", 4'h4, 32'h1);
    wrReg(4'h4, 32'hFFFF_FFFD);
    rdCheck("R8 write one clears", 4'h4, 32'h0);
    // txnEnd and txnStart both clear the count
    retries(2); txnEnd = 1; tick(); txnEnd = 0;
    retries(3);
    check("R3 end clears count", retryAbort, 0);
    txnStart = 1; tick(); txnStart = 0;
    retries(3);
    check("R3 start clears count", retryErr, 0);
    // clear wins over a retry in the same cycle
    txnStart = 1; retryHit = 1; tick(); idle();
    retries(3);
    check("R5 clear priority", retryErr, 0);
    txnStart = 1; tick(); txnStart = 0;
  endtask

  task automatic tTrdy();
    // limit 2: 2 waiting clocks fine, 3rd times out
    dataPhaseStart = 1; tick(); dataPhaseStart = 0;
    waits(2);
    check("R4 no abort at limit", trdyAbort, 0);
    waits(1);
    check("R4 trdy abort", trdyAbort, 1);
    rdCheck("R7 trdy flag bit1", 4'h4, 32'h2);
    wrReg(4'h4, 32'h2);
    waits(2); trdySeen = 1; tick(); trdySeen = 0;
    waits(2);
    check("R4 ready clears wait", trdyErr, 0);
    dataPhaseStart = 1; tick(); dataPhaseStart = 0;
    waits(2);
    dataPhaseStart = 1; tick(); dataPhaseStart = 0;
    waits(2);
    check("R4 phase start clears", trdyErr, 0);
    dataPhaseStart = 1; tick(); dataPhaseStart = 0;
  endtask

  task automatic tDisabled();
    wrReg(4'h0, 32'h0);
    retries(300);
    waits(300);
    check("R6 no aborts", {retryAbort, trdyAbort}, 0);
    rdCheck("R6 no flags", 4'h4, 32'h0);
  endtask

  task automatic tSetWins();
    wrReg(4'h0, 32'h0000_0101);
    txnStart = 1; tick(); txnStart = 0;
    retries(1);
    regAddr = 4'h4; regWrData = 32'h1; regWrEn = 1; retryHit = 1;
    tick(); idle();
    check("R9 set wins", retryErr, 1);
    check("R9 abort", retryAbort, 1);
  endtask

  initial begin
    fork
      begin
        idle();
        repeat (3) tick();
        rstN = 1'b1;
        tick();
        tReset();
        tLimitWrite();
        tRetry();
        tTrdy();
        tDisabled();
        tSetWins();
      end
      begin
        repeat (20000) @(posedge clk);
        nChk++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule